// File: doc/BRIEF.md
# Polyphase IIR Interpolator by Three

This block triples the sample rate of a signed fixed-point stream. It uses an IIR low-pass whose denominator contains only powers of z^-3. Because of that, the whole recursive part is computed once per input sample at the low rate, as a cascade of all-pole sections: one first-order section followed by two second-order sections. The low-rate coefficients are every third coefficient of the full-rate denominator. The numerator is split into three polyphase FIR branches. Each branch holds every third numerator tap, starting at offset 0, 1 or 2, and all three branches take the same cascade output as their input.

A commutator then emits the three branch results on consecutive clock cycles, branch 0 first. An input of L samples therefore yields 3L outputs. Samples arrive on a valid/ready stream. Results leave on a valid-only stream, tagged with their phase number. All coefficients are module parameters in Q(FRAC) fixed point. Every product sum is formed in a 64-bit accumulator and shifted right arithmetically (floor) by FRAC bits. The result is then clamped to the signed DW-bit range.

Top module: `iir3_interp`

## Requirements
- R1: Each accepted sample (in_valid and in_ready both high at a rising edge) gives exactly three consecutive cycles of out_valid, starting in the cycle right after the acceptance edge.
- R2: in_ready is high when no frame is being emitted and during the third output phase, and low during the first two phases. A sample offered while in_ready is low is ignored and leaves the filter state and the outputs unchanged.
- R3: out_phase reads 0, 1 and 2 in the three output cycles of a frame. The value carried in phase k is the result of polyphase branch k.
- R4: The cascade applies y = floor((x*2^FRAC - a1*y[-1] - a2*y[-2]) / 2^FRAC) per section at the input rate. The first section has no a2 term. Section state advances only on an accepted sample.
- R5: Branch k computes floor(sum_i b[3i+k]*v[n-i] / 2^FRAC), with i from 0 to NTAP-1, where v is the cascade output and b is the full numerator. All branches share the same v.
- R6: Every section output and branch output saturates to [-2^(DW-1), 2^(DW-1)-1] and never wraps.
- R7: Synchronous reset clears all filter state and the commutator. In the cycle after reset, out_valid is 0, in_ready is 1 and out_data is 0. The next frame starts at phase 0 with a response identical to a fresh filter.
- R8: When a new sample is offered in every third output phase, out_valid stays high without a gap and one sample is taken every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Signed interpolated sample |
| out_phase | output | 2 | Polyphase branch index of out_data |

## Verification
The branch results for a sample accepted at rising edge E appear on out_data one, two and three cycles later, that is, after edges E, E+1 and E+2. in_ready rises for the third of those cycles. The bench drives inputs and samples outputs on falling edges. Right after the acceptance edge it reads phase 0, then reads phases 1 and 2 on the next two falling edges. During the third of these it offers the next sample, so back-to-back frames line up without idle cycles. A behavioural integer model, stepped once per accepted sample, supplies the three expected values.

// File: rtl/iir3_pkg.sv
package iir3_pkg;
  typedef logic signed [63:0] acc_t;
  localparam int PHASES = 3;

  // Floor division by 2^frac (arithmetic shift)
  function automatic acc_t rescale(input acc_t v, input int frac);
    return v >>> frac;
  endfunction

  function automatic acc_t lim_hi(input int w);
    return (acc_t'(1) <<< (w - 1)) - acc_t'(1);
  endfunction

  function automatic acc_t lim_lo(input int w);
    return -(acc_t'(1) <<< (w - 1));
  endfunction

  function automatic acc_t mul(input acc_t a, input acc_t b);
    return a * b;
  endfunction
endpackage

// File: rtl/iir3_pole_sec.sv
module iir3_pole_sec
  import iir3_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int ORDER = 2,
  parameter logic [ORDER*CW-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] y_out
);
  logic signed [DW-1:0] w1;
  acc_t fb2, acc, scaled;
  logic sat_hi, sat_lo;

  generate
    if (ORDER == 2) begin : g_o2
      logic signed [DW-1:0] w2;
      always_ff @(posedge clk) begin
        if (rst)      w2 <= '0;
        else if (adv) w2 <= w1;
      end
      assign fb2 = mul(acc_t'($signed(COEF[2*CW-1:CW])), acc_t'(w2));
    end else begin : g_o1
      assign fb2 = '0;
    end
  endgenerate

  always_comb begin
    acc    = (acc_t'(x_in) <<< FRAC)
           - mul(acc_t'($signed(COEF[CW-1:0])), acc_t'(w1)) - fb2;
    scaled = rescale(acc, FRAC);
    sat_hi = scaled > lim_hi(DW);
    sat_lo = scaled < lim_lo(DW);
    if (sat_hi)      y_out = {1'b0, {(DW-1){1'b1}}};
    else if (sat_lo) y_out = {1'b1, {(DW-1){1'b0}}};
    else             y_out = DW'(scaled);
  end

  always_ff @(posedge clk) begin
    if (rst)      w1 <= '0;
    else if (adv) w1 <= y_out;
  end

  AST_SEC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (acc < 0) == (y_out < 0)); // R6
endmodule

// File: rtl/iir3_fir_branch.sv
module iir3_fir_branch
  import iir3_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int NTAP = 3,
  parameter logic [NTAP*CW-1:0] TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [DW-1:0] v_in,
  output logic signed [DW-1:0] y_out
);
  logic signed [DW-1:0] dl [NTAP-1];
  logic signed [DW-1:0] tv [NTAP];
  acc_t acc, scaled;

  always_comb begin
    tv[0] = v_in;
    for (int i = 1; i < NTAP; i++) tv[i] = dl[i-1];
    acc = '0;
    for (int i = 0; i < NTAP; i++)
      acc = acc + mul(acc_t'($signed(TAPS[i*CW +: CW])), acc_t'(tv[i]));
    scaled = rescale(acc, FRAC);
    if (scaled > lim_hi(DW))      y_out = {1'b0, {(DW-1){1'b1}}};
    else if (scaled < lim_lo(DW)) y_out = {1'b1, {(DW-1){1'b0}}};
    else                          y_out = DW'(scaled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP-1; i++) dl[i] <= '0;
    end else if (adv) begin
      dl[0] <= v_in;
      for (int i = 1; i < NTAP-1; i++) dl[i] <= dl[i-1];
    end
  end

  AST_BR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (acc < 0) == (y_out < 0)); // R6
endmodule

// File: rtl/iir3_commutator.sv
module iir3_commutator
  import iir3_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [PHASES*DW-1:0]   br_data,
  output logic                   out_valid,
  output logic signed [DW-1:0]   out_data,
  output logic [1:0]             phase,
  output logic                   last_phase
);
  localparam logic [1:0] PH_LAST = 2'(PHASES - 1);
  logic [DW-1:0] hold [PHASES];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      phase     <= '0;
      for (int k = 0; k < PHASES; k++) hold[k] <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      phase     <= '0;
      for (int k = 0; k < PHASES; k++) hold[k] <= br_data[k*DW +: DW];
    end else if (out_valid) begin
      if (phase == PH_LAST) begin
        out_valid <= 1'b0;
        phase     <= '0;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  assign out_data   = $signed(hold[phase]);
  assign last_phase = out_valid && (phase == PH_LAST);

  AST_LOAD_TO_P0: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid && phase == 2'd0); // R3
  AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && phase != PH_LAST) |=> out_valid); // R1
  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && phase == PH_LAST && !load) |=> !out_valid); // R1
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_LAST); // R3
  AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |-> (!out_valid || phase == PH_LAST)); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && phase == 2'd0); // R7
endmodule

// File: rtl/iir3_interp.sv
module iir3_interp
  import iir3_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int NTAP = 3,
  parameter logic signed [CW-1:0] S1_A1 = -16'sd8192,
  parameter logic signed [CW-1:0] S2_A1 = -16'sd9830,
  parameter logic signed [CW-1:0] S2_A2 = 16'sd3277,
  parameter logic signed [CW-1:0] S3_A1 = -16'sd4915,
  parameter logic signed [CW-1:0] S3_A2 = 16'sd1638,
  parameter logic [PHASES*NTAP*CW-1:0] NUM_TAPS = {
    16'sd200, 16'sd300, 16'sd400, 16'sd700, 16'sd800,
    16'sd900, 16'sd1400, 16'sd1500, 16'sd1200}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [1:0]           out_phase
);
  // Polyphase split: branch k takes numerator taps k, k+3, k+6, ...
  function automatic logic [NTAP*CW-1:0] phase_taps(input int k);
    logic [NTAP*CW-1:0] t;
    t = '0;
    for (int i = 0; i < NTAP; i++)
      t[i*CW +: CW] = NUM_TAPS[(PHASES*i + k)*CW +: CW];
    return t;
  endfunction

  logic accept, last_phase;
  logic signed [DW-1:0] s1_y, s2_y, cas_v;
  logic [PHASES*DW-1:0] br_bus;

  assign in_ready = !out_valid || last_phase;
  assign accept   = in_valid && in_ready;

  iir3_pole_sec #(.DW(DW), .CW(CW), .FRAC(FRAC), .ORDER(1), .COEF(S1_A1))
    u_sec1 (.clk(clk), .rst(rst), .adv(accept), .x_in(in_data), .y_out(s1_y));
  iir3_pole_sec #(.DW(DW), .CW(CW), .FRAC(FRAC), .ORDER(2), .COEF({S2_A2, S2_A1}))
    u_sec2 (.clk(clk), .rst(rst), .adv(accept), .x_in(s1_y), .y_out(s2_y));
  iir3_pole_sec #(.DW(DW), .CW(CW), .FRAC(FRAC), .ORDER(2), .COEF({S3_A2, S3_A1}))
    u_sec3 (.clk(clk), .rst(rst), .adv(accept), .x_in(s2_y), .y_out(cas_v));

  generate
    for (genvar k = 0; k < PHASES; k++) begin : g_branch
      iir3_fir_branch #(.DW(DW), .CW(CW), .FRAC(FRAC), .NTAP(NTAP),
                        .TAPS(phase_taps(k)))
        u_br (.clk(clk), .rst(rst), .adv(accept), .v_in(cas_v),
              .y_out(br_bus[k*DW +: DW]));
    end
  endgenerate

  iir3_commutator #(.DW(DW)) u_comm (
    .clk(clk), .rst(rst), .load(accept), .br_data(br_bus),
    .out_valid(out_valid), .out_data(out_data), .phase(out_phase),
    .last_phase(last_phase));

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid && out_phase == 2'd0); // R1
  AST_READY_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_phase == 2'd0) |=> !in_ready); // R2
endmodule

// File: tb/iir3_interp_tb.sv
`timescale 1ns/1ps
module iir3_interp_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;
  logic [1:0] out_phase;

  int checks = 0;
  int errors = 0;

  iir3_interp dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_phase(out_phase));

  always #5 clk = ~clk;

  // Independent integer model of the requirements
  localparam longint A [3][2] = '{'{-8192, 0}, '{-9830, 3277}, '{-4915, 1638}};
  localparam longint B [9] = '{1200, 1500, 1400, 900, 800, 700, 400, 300, 200};
  localparam int STIM [24] = '{12000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                               32767, 32767, 32767, -32768, -32768, 5000,
                               -7000, 100, -1, 1, 20000, -20000};
  longint st [3][2];
  longint hist [2];
  longint exp_y [3];

  function automatic longint clip(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin st[s][0] = 0; st[s][1] = 0; end
    hist[0] = 0; hist[1] = 0;
  endtask

  task automatic model_step(input longint x);
    longint v, a;
    v = x;
    for (int s = 0; s < 3; s++) begin
      a = v * 16384 - A[s][0] * st[s][0] - A[s][1] * st[s][1];
      v = clip(a >>> 14);
      st[s][1] = st[s][0];
      st[s][0] = v;
    end
    for (int k = 0; k < 3; k++) begin
      a = B[k] * v + B[3+k] * hist[0] + B[6+k] * hist[1];
      exp_y[k] = clip(a >>> 14);
    end
    hist[1] = hist[0];
    hist[0] = v;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge with in_ready high; returns at the falling edge of phase 2
  task automatic send(input longint x, input string req);
    chk(in_ready == 1'b1, {req, " R2 ready before offer"}, in_ready, 1);
    model_step(x);
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int p = 0; p < 3; p++) begin
      chk(out_valid == 1'b1, {req, " R1 valid"}, out_valid, 1);
      chk(out_phase == 2'(p), {req, " R3 phase"}, out_phase, p);
      chk(longint'(out_data) == exp_y[p], {req, " R4/R5 data"}, out_data, exp_y[p]);
      chk(in_ready == (p == 2), {req, " R2 ready in frame"}, in_ready, (p == 2));
      if (p < 2) @(negedge clk);
    end
  endtask

  initial begin
    #1ms;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    chk(out_valid == 1'b0, "R7 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);
    chk(out_data == 16'sd0, "R7 data after reset", out_data, 0);

    // Table: impulse, saturating and mixed values (R4, R5, R6)
    foreach (STIM[i]) send(STIM[i], "R6 table");
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 no fourth output", out_valid, 0);
    chk(in_ready == 1'b1, "R2 ready when idle", in_ready, 1);

    // R8: random stream, back to back, with out_valid continuous
    for (int n = 0; n < 60; n++) begin
      longint x;
      x = longint'($urandom_range(0, 65535)) - 32768;
      send(x, "R8 stream");
      if (n < 59) chk(out_valid == 1'b1, "R8 no gap", out_valid, 1);
    end
    @(negedge clk);

    // R2: offers while in_ready is low are ignored
    model_step(4000);
    in_valid = 1'b1;
    in_data  = 16'sd4000;
    @(posedge clk);
    @(negedge clk);
    in_data = -16'sd12345;
    chk(longint'(out_data) == exp_y[0], "R2 ignore p0", out_data, exp_y[0]);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready low p1", in_ready, 0);
    chk(longint'(out_data) == exp_y[1], "R2 ignore p1", out_data, exp_y[1]);
    @(negedge clk);
    in_valid = 1'b0;
    chk(longint'(out_data) == exp_y[2], "R2 ignore p2", out_data, exp_y[2]);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 junk not taken", out_valid, 0);
    send(0, "R2 state untouched");
    send(-3000, "R2 state untouched");

    // R7: reset in the middle of a frame, then fresh impulse response
    in_valid = 1'b1;
    in_data  = 16'sd9000;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(out_valid == 1'b0, "R7 valid after mid reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 ready after mid reset", in_ready, 1);
    chk(out_data == 16'sd0, "R7 data after mid reset", out_data, 0);
    send(12000, "R7 fresh impulse");
    for (int n = 0; n < 5; n++) send(0, "R7 fresh tail");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule